// File: doc/BRIEF.md
# DMA Page Register File

This block holds the page registers that widen a 16-bit DMA channel address into a 32-bit physical address. It sits on a byte-wide I/O port bus. A page window of eight ports starts at `PAGE_BASE`. When `HIGH_EN` is set, a second eight-port window at `HIGH_BASE` holds a high-page bank. Only four offsets inside each window are live, and they reach the four channels in a scrambled order. Writes to the other offsets are dropped, and reads from them return zero.

A consumer picks a channel on `sel_chan` and drives that channel's running address on `cur_addr`. The block then returns the full physical address as a combinational function of the stored bytes. The eight-bit controller uses the default bases 0x80 and 0x480. The sixteen-bit controller is built with 0x88 and 0x488. Decode is a single-cycle compare against the base. The read data is registered.

There is no sequencing state. Each access completes in the cycle it is presented, and read data appears one clock later.

Top module: `dma_page_bank`

## Requirements
- R1: After reset every page and high-page byte is zero, `io_rdata` is zero, and `phys_addr` equals `cur_addr` zero-extended for every channel.
- R2: Inside the page window, port offsets 1, 2, 3 and 7 (`io_addr[2:0]`) select channels 2, 3, 1 and 0. A write with `io_wr` high stores `io_wdata` into that channel's page byte.
- R3: A read with `io_rd` high at a live page offset returns that channel's page byte on `io_rdata` after the next rising clock edge.
- R4: Offsets 0, 4, 5 and 6 of either window are invalid. A write there changes no register, and a read there returns 0.
- R5: When `HIGH_EN` is 1, the window at `HIGH_BASE` uses the same offset-to-channel map for reading and writing the high-page bytes.
- R6: `phys_addr` is formed as follows: bit 31 is 0, bits 30:24 hold high-page bits 6:0 of channel `sel_chan`, bits 23:16 hold its page byte, and bits 15:0 hold `cur_addr`. It follows its inputs in the same cycle.
- R7: When `HIGH_EN` is 0, the high window is not decoded. Writes there are dropped, reads there return 0, and `phys_addr[30:24]` stays 0.
- R8: `io_rdata` holds its value in every cycle in which `io_rd` is low.
- R9: A read and a write to the same register in the same cycle return the value held before the write. The new value is seen by the next read.
- R10: Addresses outside both windows are ignored. A write there changes nothing, and a read there returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| sel_chan | input | 2 | Channel whose physical address is formed |
| cur_addr | input | 16 | Current 16-bit address of the selected channel |
| phys_addr | output | 32 | Composed physical address |

## Verification
Every cycle, the assertions check three things. A decoded write lands in exactly the addressed channel byte, and every other byte keeps its value. A read that misses returns zero on the next cycle. The read register holds while no read is strobed.

Some behaviour depends on the address map and the build parameters, and only the bench scenarios can show it. This covers the scrambled offset-to-channel order, the high page losing its top bit in `phys_addr`, and the behaviour of a sixteen-bit controller built without a high bank. It also covers ordering when a read and a write hit the same register in the same cycle.

// File: rtl/dma_page_pkg.sv
package dma_page_pkg;
    localparam int NCH   = 4;
    localparam int CH_W  = $clog2(NCH);
    localparam int OFF_W = 3;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic            ok;
        logic [CH_W-1:0] ch;
    } chan_sel_t;

    // Offset to channel map: 1->2, 2->3, 3->1, 7->0, others invalid
    function automatic chan_sel_t chan_of(input logic [OFF_W-1:0] off);
        chan_sel_t r;
        r = '0;
        unique case (off)
            3'd1: r = '{ok: 1'b1, ch: 2'd2};
            3'd2: r = '{ok: 1'b1, ch: 2'd3};
            3'd3: r = '{ok: 1'b1, ch: 2'd1};
            3'd7: r = '{ok: 1'b1, ch: 2'd0};
            default: r = '0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/dma_page_decode.sv
module dma_page_decode
    import dma_page_pkg::*;
#(
    parameter int          PORT_W    = 16,
    parameter logic [15:0] PAGE_BASE = 16'h0080,
    parameter logic [15:0] HIGH_BASE = 16'h0480,
    parameter bit          HIGH_EN   = 1'b1
) (
    input  logic [PORT_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic              lo_we,
    output logic              hi_we,
    output logic              lo_re,
    output logic              hi_re,
    output logic [CH_W-1:0]   ch
);
    localparam int TAG_W = PORT_W - OFF_W;

    logic      in_lo;
    logic      in_hi;
    chan_sel_t sel;

    always_comb begin
        sel   = chan_of(io_addr[OFF_W-1:0]);
        in_lo = (io_addr[PORT_W-1:OFF_W] == PAGE_BASE[PORT_W-1:OFF_W]) && sel.ok;
        in_hi = HIGH_EN && (io_addr[PORT_W-1:OFF_W] == HIGH_BASE[PORT_W-1:OFF_W]) && sel.ok;
        lo_we = io_wr && in_lo;
        hi_we = io_wr && in_hi;
        lo_re = io_rd && in_lo;
        hi_re = io_rd && in_hi;
        ch    = sel.ch;
    end

    logic [TAG_W-1:0] unused_tag;
    assign unused_tag = '0;
endmodule

// File: rtl/dma_page_regs.sv
module dma_page_regs
    import dma_page_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [CH_W-1:0]             ch,
    input  logic [BYTE_W-1:0]           wdata,
    output logic [NCH-1:0][BYTE_W-1:0]  q
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q[i] <= '0;
            else if (we && ch == CH_W'(i))
                q[i] <= wdata;
        end

        // R2
        page_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we && ch == CH_W'(i)) |=> q[i] == $past(wdata));

        // R4
        page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && ch == CH_W'(i)) |=> $stable(q[i]));
    end
endmodule

// File: rtl/dma_page_compose.sv
module dma_page_compose
    import dma_page_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int HI_KEEP = 7,
    localparam int PHYS_W = 1 + HI_KEEP + BYTE_W + ADDR_W
) (
    input  logic [BYTE_W-1:0] hi_byte,
    input  logic [BYTE_W-1:0] page_byte,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic [PHYS_W-1:0] phys
);
    logic hi_top_unused;

    always_comb begin
        phys          = {1'b0, hi_byte[HI_KEEP-1:0], page_byte, cur_addr};
        hi_top_unused = hi_byte[BYTE_W-1];
    end
endmodule

// File: rtl/dma_page_bank.sv
module dma_page_bank
    import dma_page_pkg::*;
#(
    parameter logic [15:0] PAGE_BASE = 16'h0080,
    parameter logic [15:0] HIGH_BASE = 16'h0480,
    parameter bit          HIGH_EN   = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    input  logic [1:0]  sel_chan,
    input  logic [15:0] cur_addr,
    output logic [31:0] phys_addr
);
    logic                       lo_we, hi_we, lo_re, hi_re;
    logic [CH_W-1:0]            ch;
    logic [NCH-1:0][BYTE_W-1:0] lo_q;
    logic [NCH-1:0][BYTE_W-1:0] hi_q;
    logic [BYTE_W-1:0]          rd_mux;

    dma_page_decode #(
        .PORT_W(16), .PAGE_BASE(PAGE_BASE), .HIGH_BASE(HIGH_BASE), .HIGH_EN(HIGH_EN)
    ) u_dec (
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .lo_we(lo_we), .hi_we(hi_we), .lo_re(lo_re), .hi_re(hi_re), .ch(ch)
    );

    dma_page_regs u_lo (
        .clk(clk), .rst_n(rst_n), .we(lo_we), .ch(ch), .wdata(io_wdata), .q(lo_q)
    );

    if (HIGH_EN) begin : g_hi
        dma_page_regs u_hi (
            .clk(clk), .rst_n(rst_n), .we(hi_we), .ch(ch), .wdata(io_wdata), .q(hi_q)
        );
    end else begin : g_no_hi
        assign hi_q = '0;
    end

    always_comb begin
        if (lo_re)
            rd_mux = lo_q[ch];
        else if (hi_re)
            rd_mux = hi_q[ch];
        else
            rd_mux = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            io_rdata <= '0;
        else if (io_rd)
            io_rdata <= rd_mux;
    end

    dma_page_compose #(.ADDR_W(16), .HI_KEEP(7)) u_cmp (
        .hi_byte(hi_q[sel_chan]), .page_byte(lo_q[sel_chan]),
        .cur_addr(cur_addr), .phys(phys_addr)
    );

    // R4
    rd_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !lo_re && !hi_re) |=> io_rdata == '0);

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> $stable(io_rdata));
endmodule

// File: tb/dma_page_bank_tb.sv
module dma_page_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  rdata_a, rdata_b;
    logic [1:0]  sel_chan = '0;
    logic [15:0] cur_addr = 16'h1234;
    logic [31:0] phys_a, phys_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dma_page_bank u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(rdata_a), .sel_chan(sel_chan),
        .cur_addr(cur_addr), .phys_addr(phys_a)
    );

    dma_page_bank #(.PAGE_BASE(16'h0088), .HIGH_BASE(16'h0488), .HIGH_EN(1'b0)) u_nohi (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(rdata_b), .sel_chan(sel_chan),
        .cur_addr(cur_addr), .phys_addr(phys_b)
    );

    // {is_read, addr, wdata, expected}
    localparam int NV = 24;
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 16'h0081, 8'h11, 8'h00},  // R2 offset 1 -> ch2
        {1'b0, 16'h0082, 8'h22, 8'h00},  // R2 offset 2 -> ch3
        {1'b0, 16'h0083, 8'h33, 8'h00},  // R2 offset 3 -> ch1
        {1'b0, 16'h0087, 8'h77, 8'h00},  // R2 offset 7 -> ch0
        {1'b0, 16'h0080, 8'hAA, 8'h00},  // R4 invalid
        {1'b0, 16'h0084, 8'hAB, 8'h00},  // R4 invalid
        {1'b0, 16'h0085, 8'hAC, 8'h00},  // R4 invalid
        {1'b0, 16'h0086, 8'hAD, 8'h00},  // R4 invalid
        {1'b1, 16'h0081, 8'h00, 8'h11},  // R3
        {1'b1, 16'h0082, 8'h00, 8'h22},  // R3
        {1'b1, 16'h0083, 8'h00, 8'h33},  // R3
        {1'b1, 16'h0087, 8'h00, 8'h77},  // R3
        {1'b1, 16'h0080, 8'h00, 8'h00},  // R4
        {1'b1, 16'h0084, 8'h00, 8'h00},  // R4
        {1'b1, 16'h0086, 8'h00, 8'h00},  // R4
        {1'b0, 16'h0481, 8'h91, 8'h00},  // R5 high ch2
        {1'b0, 16'h0487, 8'hF0, 8'h00},  // R5 high ch0
        {1'b0, 16'h0485, 8'h5E, 8'h00},  // R4 high invalid
        {1'b1, 16'h0481, 8'h00, 8'h91},  // R5
        {1'b1, 16'h0487, 8'h00, 8'hF0},  // R5
        {1'b1, 16'h0485, 8'h00, 8'h00},  // R4
        {1'b0, 16'h0100, 8'h5A, 8'h00},  // R10 outside
        {1'b1, 16'h0100, 8'h00, 8'h00},  // R10
        {1'b1, 16'h0483, 8'h00, 8'h00}   // R5 untouched ch1 high
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [15:0] a);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rdata", {24'h0, rdata_a}, 32'h0);
        for (int c = 0; c < 4; c++) begin
            sel_chan = 2'(c);
            #1;
            chk("R1 phys", phys_a, 32'h0000_1234);
        end

        for (int i = 0; i < NV; i++) begin
            logic [32:0] v;
            v = VEC[i];
            if (v[32]) begin
                do_rd(v[31:16]);
                if (v[31:16] == 16'h0100)
                    chk("R10 read outside", {24'h0, rdata_a}, {24'h0, v[7:0]});
                else if (v[26])
                    chk("R5 high read", {24'h0, rdata_a}, {24'h0, v[7:0]});
                else if (v[7:0] == 8'h00)
                    chk("R4 invalid read", {24'h0, rdata_a}, 32'h0);
                else
                    chk("R3 page read", {24'h0, rdata_a}, {24'h0, v[7:0]});
            end else begin
                do_wr(v[31:16], v[15:8]);
            end
        end

        // R6 composed address per channel
        sel_chan = 2'd2; #1; chk("R6 ch2", phys_a, 32'h1111_1234);
        sel_chan = 2'd0; #1; chk("R6 ch0 top bit dropped", phys_a, 32'h7077_1234);
        sel_chan = 2'd3; #1; chk("R6 ch3", phys_a, 32'h0022_1234);
        sel_chan = 2'd1; cur_addr = 16'hFFFF; #1;
        chk("R6 ch1", phys_a, 32'h0033_FFFF);
        cur_addr = 16'h1234;

        // R8 read data holds without a read strobe
        do_rd(16'h0083);
        repeat (3) @(negedge clk);
        chk("R8 hold", {24'h0, rdata_a}, 32'h33);
        do_wr(16'h0083, 8'h3C);
        chk("R8 hold after write", {24'h0, rdata_a}, 32'h33);

        // R9 same-cycle read and write
        @(negedge clk);
        io_addr = 16'h0082; io_wdata = 8'h5C; io_wr = 1'b1; io_rd = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
        chk("R9 old value", {24'h0, rdata_a}, 32'h22);
        do_rd(16'h0082);
        chk("R9 new value", {24'h0, rdata_a}, 32'h5C);

        // R7 sixteen-bit controller without high bank
        do_wr(16'h0489, 8'h7F);
        do_rd(16'h0489);
        chk("R7 high read zero", {24'h0, rdata_b}, 32'h0);
        do_wr(16'h0089, 8'h44);
        sel_chan = 2'd2; #1;
        chk("R7 phys no high", phys_b, 32'h0044_1234);
        chk("R10 other window untouched", phys_a, 32'h1111_1234);
        do_rd(16'h0089);
        chk("R3 second controller read", {24'h0, rdata_b}, 32'h44);

        // R1 reset again clears the banks
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        do_rd(16'h0081);
        chk("R1 cleared page", {24'h0, rdata_a}, 32'h0);
        #1;
        chk("R1 cleared phys", phys_a, 32'h0000_1234);

        finish_run();
    end
endmodule